// File: doc/BRIEF.md
# Up/Down Timer with Equality Compare and Toggle PWM

A 10-bit up/down counter with a selectable active length of 4, 6, 8 or 10 bits. It advances one step on a prescaled tick from the system clock, or on active edges of one of two external event inputs. Those inputs are already synchronised and debounced. A polarity bit per input selects which edge counts.

An equality comparator checks each new count against a compare register and raises a one-cycle interrupt on a match. The comparator can check all 10 bits or only the active length. A toggle-style PWM level flips on every roll-over and every compare match. With PWM enabled, the counter stops itself after the compare match.

Software drives the block through a simple write port. The port has four addresses: load value, compare value, control and event configuration.

Top module: `tmr_cmp_pwm`

## Requirements
- R1: After reset, count_o is 0, irq_roll_o and irq_cmp_o are 0, pwm_o is 0, and the compare, control and event registers are all zero.
- R2: Register map, written through wr_addr_i:
  - Address 0 loads the counter.
  - Address 1 sets the compare value.
  - Address 2 is control: bit0 run, bit1 down, bit2 cmp_en, bit3 full, bits5:4 len, bit6 pwm_en.
  - With run=1 and event mode off, each cycle with tick_i high steps count_o by one (down when bit1=1, up otherwise), visible the next cycle.
  - With run=0, or with tick_i low, count_o holds.
- R3: len codes 0, 1, 2 and 3 select active lengths of 4, 6, 8 and 10 bits. irq_roll_o pulses for one cycle after any step that leaves the active low part all-ones when counting up, or zero when counting down.
- R4: The counter always carries or borrows across all 10 bits. So with full compare and a shorter length, the number of roll-overs before the match equals the value held in the unused upper bits.
- R5: Address 3 is event configuration: bit0 event mode, bit1 input select (0 for evt_i[0], 1 for evt_i[1]), bit2 invert for input 0, bit3 invert for input 1. In event mode tick_i is ignored. The counter steps when the selected input rises (invert 0) or falls (invert 1) between two consecutive cycles while run=1.
- R6: With cmp_en=1, irq_cmp_o pulses for one cycle after a step whose new count equals the compare value. Full mode (full=1) compares all 10 bits; limited mode compares only the active length.
- R7: irq_cmp_o never rises while cmp_en=0, and never rises just because the count equals the compare value when the counter is started.
- R8: Every write to address 0 clears cmp_en.
- R9: While cmp_en=0, the PWM level is forced to the down bit (0 for up, 1 for down) on the next cycle. While cmp_en=1, the level toggles once on each step that rolls over, matches, or does both.
- R10: With pwm_en=1, a compare match clears run, so the count freezes at the match value. With pwm_en=0, counting continues.
- R11: pwm_o shows the PWM level when pwm_en=1 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 10 | Register write data |
| tick_i | input | 1 | Prescaled count enable for internal mode |
| evt_i | input | 2 | Synchronised event inputs |
| count_o | output | 10 | Current counter value |
| irq_roll_o | output | 1 | Roll-over interrupt pulse |
| irq_cmp_o | output | 1 | Compare match interrupt pulse |
| pwm_o | output | 1 | PWM output level |

## Verification
Every result is one register away from its cause. A write, a tick or an event edge taken at a rising edge shows on count_o, irq_roll_o, irq_cmp_o and the PWM level in the following cycle, so each interrupt is high for exactly that cycle. The bench drives on the falling edge and lets exactly one rising edge pass. It then samples all four outputs at the next falling edge, against a reference that it advances by one step per cycle. The sweep covers every length, direction, compare mode and PWM setting, plus edge patterns on both event inputs with both polarities.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int LEN_SEL_W = 2;
  localparam int LEN_STEP  = 2;

  typedef enum logic [1:0] {
    ADDR_LOAD = 2'd0,
    ADDR_CMP  = 2'd1,
    ADDR_CTRL = 2'd2,
    ADDR_EVT  = 2'd3
  } tmr_addr_e;

  typedef struct packed {
    logic                 pwm_en;
    logic [LEN_SEL_W-1:0] len;
    logic                 full;
    logic                 cmp_en;
    logic                 down;
    logic                 run;
  } tmr_ctrl_t;

  typedef struct packed {
    logic inv1;
    logic inv0;
    logic sel;
    logic evt_mode;
  } tmr_evt_t;
endpackage

// File: rtl/tmr_edge_sel.sv
module tmr_edge_sel #(
  parameter int N_EVT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EVT-1:0] evt_i,
  input  logic [N_EVT-1:0] inv_i,
  input  logic             sel_i,
  output logic             edge_o
);
  logic [N_EVT-1:0] lvl;
  logic             cur, prev_q;

  for (genvar g = 0; g < N_EVT; g++) begin : g_pol
    assign lvl[g] = evt_i[g] ^ inv_i[g];
  end

  assign cur = lvl[sel_i];

  // registered copy tracks the selected level even while stopped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= cur;
  end

  assign edge_o = cur & ~prev_q;
endmodule

// File: rtl/tmr_step.sv
module tmr_step
  import tmr_pkg::*;
#(
  parameter int W = 10
) (
  input  logic [W-1:0]         cnt_i,
  input  logic                 down_i,
  input  logic [LEN_SEL_W-1:0] len_i,
  output logic [W-1:0]         nxt_o,
  output logic [W-1:0]         mask_o,
  output logic                 wrap_o
);
  localparam int MAX_LEN = (1 << LEN_SEL_W) - 1;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  always_comb begin
    mask_o = ONES >> (LEN_STEP * (MAX_LEN - int'(len_i)));
    // full-width arithmetic: upper bits carry on roll-over
    nxt_o  = down_i ? cnt_i - 1'b1 : cnt_i + 1'b1;
    wrap_o = down_i ? ((cnt_i & mask_o) == '0) : ((cnt_i & mask_o) == mask_o);
  end
endmodule

// File: rtl/tmr_cmp.sv
module tmr_cmp #(
  parameter int W = 10
) (
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] ref_i,
  input  logic [W-1:0] mask_i,
  input  logic         full_i,
  output logic         hit_o
);
  logic [W-1:0] sel_mask;

  assign sel_mask = full_i ? {W{1'b1}} : mask_i;
  assign hit_o    = ((val_i ^ ref_i) & sel_mask) == '0;
endmodule

// File: rtl/tmr_cmp_pwm.sv
module tmr_cmp_pwm
  import tmr_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int N_EVT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             tick_i,
  input  logic [N_EVT-1:0] evt_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_roll_o,
  output logic             irq_cmp_o,
  output logic             pwm_o
);
  localparam int CTRL_W = $bits(tmr_ctrl_t);
  localparam int EVT_W  = $bits(tmr_evt_t);

  logic [CNT_W-1:0] cnt_q, cmp_q, nxt, mask;
  tmr_ctrl_t        ctrl_q;
  tmr_evt_t         evt_q;
  logic             pwm_q, irq_roll_q, irq_cmp_q;
  logic             evt_edge, wrap, cmp_hit, step, hit;

  tmr_edge_sel #(.N_EVT(N_EVT)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (evt_i),
    .inv_i ({evt_q.inv1, evt_q.inv0}),
    .sel_i (evt_q.sel),
    .edge_o(evt_edge)
  );

  tmr_step #(.W(CNT_W)) u_step (
    .cnt_i (cnt_q),
    .down_i(ctrl_q.down),
    .len_i (ctrl_q.len),
    .nxt_o (nxt),
    .mask_o(mask),
    .wrap_o(wrap)
  );

  tmr_cmp #(.W(CNT_W)) u_cmp (
    .val_i (nxt),
    .ref_i (cmp_q),
    .mask_i(mask),
    .full_i(ctrl_q.full),
    .hit_o (cmp_hit)
  );

  assign step = ctrl_q.run & (evt_q.evt_mode ? evt_edge : tick_i);
  assign hit  = ctrl_q.cmp_en & cmp_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      cmp_q      <= '0;
      ctrl_q     <= '0;
      evt_q      <= '0;
      pwm_q      <= 1'b0;
      irq_roll_q <= 1'b0;
      irq_cmp_q  <= 1'b0;
    end else begin
      irq_roll_q <= step & wrap;
      irq_cmp_q  <= step & hit;
      if (step) cnt_q <= nxt;
      if (step && hit && ctrl_q.pwm_en) ctrl_q.run <= 1'b0;
      if (!ctrl_q.cmp_en)             pwm_q <= ctrl_q.down;
      else if (step && (wrap || hit)) pwm_q <= ~pwm_q;
      // software writes take priority over self-updates
      if (wr_en_i) begin
        unique case (tmr_addr_e'(wr_addr_i))
          ADDR_LOAD: begin
            cnt_q         <= wr_data_i;
            ctrl_q.cmp_en <= 1'b0;
          end
          ADDR_CMP:  cmp_q  <= wr_data_i;
          ADDR_CTRL: ctrl_q <= tmr_ctrl_t'(wr_data_i[CTRL_W-1:0]);
          ADDR_EVT:  evt_q  <= tmr_evt_t'(wr_data_i[EVT_W-1:0]);
          default: ;
        endcase
      end
    end
  end

  assign count_o    = cnt_q;
  assign irq_roll_o = irq_roll_q;
  assign irq_cmp_o  = irq_cmp_q;
  assign pwm_o      = ctrl_q.pwm_en & pwm_q;
endmodule

// File: rtl/tmr_cmp_pwm_chk.sv
module tmr_cmp_pwm_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [1:0]       wr_addr_i,
  input logic [CNT_W-1:0] count_o,
  input logic             irq_roll_o,
  input logic             irq_cmp_o,
  input tmr_ctrl_t        ctrl_q,
  input logic             pwm_q
);
  // R7
  cmp_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_cmp_o |-> $past(ctrl_q.cmp_en));

  // R8
  load_clears_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_LOAD) |=> !ctrl_q.cmp_en);

  // R9
  pwm_start_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.cmp_en |=> (pwm_q == $past(ctrl_q.down)));

  // R10
  pwm_self_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_cmp_o && $past(ctrl_q.pwm_en) && !$past(wr_en_i)) |-> !ctrl_q.run);

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.run && !wr_en_i) |=> $stable(count_o));

  // R3
  roll_needs_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_roll_o |-> $past(ctrl_q.run));
endmodule

bind tmr_cmp_pwm tmr_cmp_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .count_o   (count_o),
  .irq_roll_o(irq_roll_o),
  .irq_cmp_o (irq_cmp_o),
  .ctrl_q    (ctrl_q),
  .pwm_q     (pwm_q)
);

// File: tb/tmr_cmp_pwm_test.sv
`timescale 1ns/1ps
module tmr_cmp_pwm_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [9:0] wr_data = '0;
  logic       tick = 1'b0;
  logic [1:0] evt = '0;
  logic [9:0] count;
  logic       irq_roll, irq_cmp, pwm;

  int n_run = 0, n_fail = 0, cyc_cnt = 0;
  bit done = 0;

  // reference state
  logic [9:0] m_cnt = '0, m_cmp = '0;
  logic [6:0] m_ctrl = '0;
  logic [3:0] m_evt = '0;
  logic       m_pwm = 1'b0, m_prev = 1'b0, e_roll = 1'b0, e_cmp = 1'b0;

  always #2.5 clk = ~clk;

  tmr_cmp_pwm uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .tick_i(tick), .evt_i(evt), .count_o(count),
    .irq_roll_o(irq_roll), .irq_cmp_o(irq_cmp), .pwm_o(pwm)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one clock: drive at falling edge, model the rising edge, compare at next falling edge
  task automatic cyc(input logic we, input logic [1:0] a, input logic [9:0] d,
                     input logic tk, input logic [1:0] e, input string tg);
    logic lvl, edg, stp, wr, hit, pw;
    logic [9:0] msk, nx, cm;
    wr_en = we; wr_addr = a; wr_data = d; tick = tk; evt = e;
    lvl = (m_evt[1] ? e[1] : e[0]) ^ (m_evt[1] ? m_evt[3] : m_evt[2]);
    edg = lvl & ~m_prev;
    stp = m_ctrl[0] & (m_evt[0] ? edg : tk);
    msk = 10'h3FF >> (2 * (3 - int'(m_ctrl[5:4])));
    nx  = m_ctrl[1] ? m_cnt - 10'd1 : m_cnt + 10'd1;
    wr  = m_ctrl[1] ? ((m_cnt & msk) == 10'd0) : ((m_cnt & msk) == msk);
    cm  = m_ctrl[3] ? 10'h3FF : msk;
    hit = m_ctrl[2] & ((nx & cm) == (m_cmp & cm));
    pw  = !m_ctrl[2] ? m_ctrl[1] : ((stp && (wr || hit)) ? ~m_pwm : m_pwm);
    @(posedge clk);
    e_roll = stp & wr;
    e_cmp  = stp & hit;
    m_prev = lvl;
    m_pwm  = pw;
    if (stp) m_cnt = nx;
    if (stp && hit && m_ctrl[6]) m_ctrl[0] = 1'b0;
    if (we) begin
      case (a)
        2'd0: begin m_cnt = d; m_ctrl[2] = 1'b0; end
        2'd1: m_cmp = d;
        2'd2: m_ctrl = d[6:0];
        default: m_evt = d[3:0];
      endcase
    end
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    chk(count == m_cnt, {tg, " R2 count"}, count, m_cnt);
    chk(irq_roll == e_roll, {tg, " R3 irq_roll"}, irq_roll, e_roll);
    chk(irq_cmp == e_cmp, {tg, " R6 irq_cmp"}, irq_cmp, e_cmp);
    chk(pwm == (m_ctrl[6] & m_pwm), m_ctrl[6] ? {tg, " R9 pwm"} : {tg, " R11 pwm"},
        pwm, m_ctrl[6] & m_pwm);
  endtask

  task automatic wreg(input logic [1:0] a, input logic [9:0] d, input string tg);
    cyc(1'b1, a, d, 1'b0, evt, tg);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000 && !done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    int rolls;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1
    chk(count == 10'd0, "R1 count", count, 0);
    chk(!irq_roll && !irq_cmp, "R1 irqs", {irq_roll, irq_cmp}, 0);
    chk(pwm == 1'b0, "R1 pwm", pwm, 0);

    // sweep: length x direction x compare mode x pwm enable
    for (int ln = 0; ln < 4; ln++)
      for (int dn = 0; dn < 2; dn++)
        for (int fl = 0; fl < 2; fl++)
          for (int pe = 0; pe < 2; pe++) begin
            wreg(2'd2, 10'd0, "R2");
            wreg(2'd0, dn ? 10'h005 : 10'h3FA, "R8");
            wreg(2'd1, dn ? 10'h3FD : 10'h002, "R6");
            wreg(2'd2, 10'((pe << 6) | (ln << 4) | (fl << 3) | 4 | (dn << 1) | 1), "R2");
            for (int t = 0; t < 48; t++) cyc(1'b0, 2'd0, 10'd0, t[0], 2'b00, "R3");
          end

    // R7: start equal to compare raises nothing
    wreg(2'd2, 10'd0, "R7");
    wreg(2'd0, 10'h005, "R7");
    wreg(2'd1, 10'h005, "R7");
    wreg(2'd2, 10'h035, "R7");
    cyc(1'b0, 2'd0, 10'd0, 1'b1, 2'b00, "R7");
    chk(!irq_cmp, "R7 start equal", irq_cmp, 0);

    // R8: load after enabling compare disarms it
    wreg(2'd1, 10'h010, "R8");
    wreg(2'd2, 10'h035, "R8");
    wreg(2'd0, 10'h00E, "R8");
    for (int t = 0; t < 3; t++) begin
      cyc(1'b0, 2'd0, 10'd0, 1'b1, 2'b00, "R8");
      chk(!irq_cmp, "R8 disarmed", irq_cmp, 0);
    end

    // R4, R10: 4-bit length, full compare 0x023 -> two roll-overs then stop
    wreg(2'd2, 10'd0, "R4");
    wreg(2'd0, 10'h000, "R4");
    wreg(2'd1, 10'h023, "R4");
    wreg(2'd2, 10'h04D, "R4");
    rolls = 0;
    for (int t = 0; t < 60 && !irq_cmp; t++) begin
      cyc(1'b0, 2'd0, 10'd0, 1'b1, 2'b00, "R4");
      if (irq_roll) rolls++;
    end
    chk(irq_cmp == 1'b1, "R4 match reached", irq_cmp, 1);
    chk(rolls == 2, "R4 roll count", rolls, 2);
    for (int t = 0; t < 4; t++) cyc(1'b0, 2'd0, 10'd0, 1'b1, 2'b00, "R10");
    chk(count == 10'h023, "R10 frozen", count, 10'h023);

    // R5: event mode, both inputs and polarities; tick held high throughout
    for (int cfg = 0; cfg < 4; cfg++) begin
      wreg(2'd2, 10'd0, "R5");
      wreg(2'd3, 10'(((cfg >> 1) << 3) | ((cfg >> 1) << 2) | ((cfg & 1) << 1) | 1), "R5");
      wreg(2'd0, 10'h3F0, "R5");
      wreg(2'd2, 10'h030 | 10'((cfg & 1) << 1) | 10'd1, "R5");
      for (int t = 0; t < 40; t++)
        cyc(1'b0, 2'd0, 10'd0, 1'b1, 2'((t / 2) ^ (t / 3)), "R5");
    end
    wreg(2'd3, 10'd0, "R5");
    finish_run();
  end
endmodule